// File: doc/BRIEF.md
# Write-Strobe Word Receiver

This block takes in the data words of one record on an 18-bit parallel peripheral bus, on the side of the storage drive. The controller first arms a write by loading a frame count, then raises RUN. For each word the block raises a sync request (`sclk_o`). The controller answers with a write strobe (`wclk_i`), and the block latches data and parity on the clock edge that sees the strobe while the request is up. Every word must carry odd parity. A good word is passed on to a downstream formatter over a ready/valid port.

While the record is moving, the block holds `occ_o` high so that no other drive takes the bus. When the frame count runs out, it pulses `ebl_o` for one cycle and releases the bus. A word with bad parity ends the record at once. In that case `exc_o` rises and stays high, the bad word is dropped, `ebl_o` pulses early, and no further request is made. The block only ever has one request outstanding. It waits until the previous word has been taken downstream before it asks for the next one.

Top module: `wdata_strobe_rx`

## Requirements
- R1: After reset, `sclk_o`, `occ_o`, `ebl_o`, `exc_o` and `fmt_valid_o` are all 0.
- R2: RUN without a prior arm pulse (`arm_i`) starts nothing: `occ_o` and `sclk_o` stay 0.
- R3: After an arm with a nonzero count and then RUN, `occ_o` is 1 until the record ends. In the cycle where `ebl_o` is 1, `occ_o` is already 0, and both stay 0 afterwards.
- R4: Once `sclk_o` is raised, it stays high until a cycle with `wclk_i` high. A `wclk_i` seen while `sclk_o` is low captures nothing.
- R5: Each captured good word appears on `fmt_data_o` with `fmt_valid_o`, and both are held until `fmt_ready_i`. `sclk_o` is never high while `fmt_valid_o` is high.
- R6: A word is good when the XOR of its 18 data bits and the parity bit is 1 (odd parity). A bad word is not forwarded. It sets `exc_o`, which stays set until the next arm. It also gives an immediate one-cycle `ebl_o` with `occ_o` low, and no further `sclk_o`.
- R7: An arm with count 0 followed by RUN gives one `ebl_o` pulse with no `sclk_o` and no `occ_o`.
- R8: A clean record with count N delivers exactly N words, in order, and exactly one `ebl_o` pulse.
- R9: An arm pulse while `occ_o` is high is ignored: the running record still delivers its original count.
- R10: When the final word of a record has bad parity, `exc_o` is set and a single `ebl_o` pulse is issued, and that word is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Write function armed; loads count |
| count_i | input | CNT_W | Words in the record |
| run_i | input | 1 | Controller run request |
| bus_data_i | input | DATA_W | Bus data word |
| bus_par_i | input | 1 | Odd parity bit for bus data |
| wclk_i | input | 1 | Write strobe from controller |
| sclk_o | output | 1 | Word request to controller |
| occ_o | output | 1 | Bus occupied |
| ebl_o | output | 1 | End-of-block pulse |
| exc_o | output | 1 | Sticky transfer exception |
| fmt_data_o | output | DATA_W | Word to formatter |
| fmt_valid_o | output | 1 | Word valid |
| fmt_ready_i | input | 1 | Formatter accepts word |

## Verification
The end of the count and a parity failure can land on the same strobe when the final word of a record is corrupted. Either one alone would end the record. The bench provokes this by flipping the parity of the last word in directed records and of randomly chosen words elsewhere. It then checks that there is exactly one `ebl_o` pulse, that `exc_o` is set, and that the delivered word count equals the index of the bad word. Backpressure is drawn at random on the same cycles, so the last delivery and the end pulse also overlap.

// File: rtl/wdata_strobe_rx.sv
module wdata_strobe_rx #(
  parameter int DATA_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_par_i,
  input  logic              wclk_i,
  output logic              sclk_o,
  output logic              occ_o,
  output logic              ebl_o,
  output logic              exc_o,
  output logic [DATA_W-1:0] fmt_data_o,
  output logic              fmt_valid_o,
  input  logic              fmt_ready_i
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              armed, occ, req, ebl, err, valid;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] data;

  wire take   = req & wclk_i;
  wire par_ok = ^{bus_data_i, bus_par_i};
  wire start  = armed & run_i & ~occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      occ   <= 1'b0;
      req   <= 1'b0;
      ebl   <= 1'b0;
      err   <= 1'b0;
      valid <= 1'b0;
      cnt   <= '0;
      data  <= '0;
    end else begin
      ebl <= 1'b0;
      if (valid && fmt_ready_i) valid <= 1'b0;
      if (arm_i && !occ) begin
        armed <= 1'b1;
        cnt   <= count_i;
        err   <= 1'b0;
      end else if (start) begin
        armed <= 1'b0;
        if (cnt == '0) ebl <= 1'b1;
        else           occ <= 1'b1;
      end else if (take) begin
        req <= 1'b0;
        if (!par_ok) begin
          err <= 1'b1;
          ebl <= 1'b1;
          occ <= 1'b0;
        end else begin
          valid <= 1'b1;
          data  <= bus_data_i;
          cnt   <= cnt - ONE;
          if (cnt == ONE) begin
            ebl <= 1'b1;
            occ <= 1'b0;
          end
        end
      end else if (occ && !req && !valid) begin
        req <= 1'b1;
      end
    end
  end

  assign sclk_o      = req;
  assign occ_o       = occ;
  assign ebl_o       = ebl;
  assign exc_o       = err;
  assign fmt_data_o  = data;
  assign fmt_valid_o = valid;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o && !wclk_i |=> sclk_o);
  // R4
  req_needs_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> occ_o);
  // R5
  req_vs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_o && fmt_valid_o));
  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_valid_o && !fmt_ready_i |=> fmt_valid_o && $stable(fmt_data_o));
  // R3
  end_frees_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ebl_o |-> !occ_o && !sclk_o);
  // R6
  exc_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_o) |-> ebl_o);
  // R3
  ebl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ebl_o |=> !ebl_o);

endmodule

// File: tb/wdata_strobe_rx_tb.sv
module wdata_strobe_rx_tb;
  localparam int CLK_T  = 10;
  localparam int DATA_W = 18;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic run_i = 1'b0;
  logic [DATA_W-1:0] bus_data_i = '0;
  logic bus_par_i = 1'b0;
  logic wclk_i = 1'b0;
  logic fmt_ready_i = 1'b0;
  logic sclk_o, occ_o, ebl_o, exc_o, fmt_valid_o;
  logic [DATA_W-1:0] fmt_data_o;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] words [64];

  always #(CLK_T/2) clk = ~clk;

  wdata_strobe_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .count_i(count_i), .run_i(run_i),
    .bus_data_i(bus_data_i), .bus_par_i(bus_par_i), .wclk_i(wclk_i),
    .sclk_o(sclk_o), .occ_o(occ_o), .ebl_o(ebl_o), .exc_o(exc_o),
    .fmt_data_o(fmt_data_o), .fmt_valid_o(fmt_valid_o), .fmt_ready_i(fmt_ready_i));

  function automatic logic good_par(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  function automatic int exp_words(input int n, input int bad);
    return (bad < n) ? bad : n;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic record(input int n, input int bad, input logic arm_mid);
    int sent = 0, got = 0, ebls = 0, sclk_seen = 0;
    logic p_sclk = 1'b0, p_w = 1'b0, fin = 1'b0;
    for (int i = 0; i < 64; i++) words[i] = DATA_W'($urandom);
    @(negedge clk);
    arm_i = 1'b1; count_i = CNT_W'(n);
    @(negedge clk);
    arm_i = 1'b0; run_i = 1'b1;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      @(negedge clk);
      if (p_sclk && !p_w) chk(sclk_o, "R4 request dropped without strobe", sclk_o, 1);
      if (sclk_o) begin
        sclk_seen++;
        if (!occ_o) chk(1'b0, "R3 request without occupancy", occ_o, 1);
        if (fmt_valid_o) chk(1'b0, "R5 request while word pending", fmt_valid_o, 0);
      end
      if (ebl_o) begin
        ebls++;
        chk(!occ_o, "R3 occupancy at end pulse", occ_o, 0);
      end
      arm_i = arm_mid && (cyc == 3);
      count_i = arm_i ? CNT_W'(5) : count_i;
      fmt_ready_i = ($urandom % 3) != 0;
      if (fmt_valid_o && fmt_ready_i) begin
        chk(fmt_data_o == words[got], "R5/R8 delivered word", int'(fmt_data_o), int'(words[got]));
        got++;
      end
      wclk_i = 1'b0;
      if (sclk_o && ($urandom % 2 == 0)) begin
        wclk_i = 1'b1;
        bus_data_i = words[sent];
        bus_par_i = (sent == bad) ? ~good_par(words[sent]) : good_par(words[sent]);
        sent++;
      end else if (!sclk_o && ($urandom % 4 == 0)) begin
        wclk_i = 1'b1;
        bus_data_i = DATA_W'($urandom);
        bus_par_i = good_par(bus_data_i);
      end
      p_sclk = sclk_o; p_w = wclk_i;
      fin = (ebls > 0) && !fmt_valid_o;
      if (cyc == 2999) chk(1'b0, "watchdog record hung", cyc, 0);
    end
    wclk_i = 1'b0; run_i = 1'b0; arm_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(got == exp_words(n, bad), (bad < n) ? "R6 words before bad one" : "R8 word count", got, exp_words(n, bad));
    chk(ebls == 1, "R8 single end pulse", ebls, 1);
    chk(exc_o == (bad < n), "R6 sticky exception", exc_o, int'(bad < n));
    chk(!sclk_o && !occ_o, "R6 no request after end", sclk_o, 0);
    if (n == 0) chk(sclk_seen == 0, "R7 no request for empty record", sclk_seen, 0);
  endtask

  initial begin
    #(CLK_T * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!sclk_o && !occ_o && !ebl_o && !exc_o && !fmt_valid_o, "R1 reset outputs",
        {sclk_o, occ_o, ebl_o, exc_o, fmt_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (occ_o || sclk_o) chk(1'b0, "R2 run without arm", occ_o, 0);
    end
    chk(!occ_o && !sclk_o && !ebl_o, "R2 idle after run without arm", occ_o, 0);
    run_i = 1'b0;
    record(4, 99, 1'b0);     // R8 directed
    record(0, 99, 1'b0);     // R7
    record(6, 99, 1'b1);     // R9 arm mid-transfer ignored
    record(5, 4, 1'b0);      // R10 bad final word
    record(1, 0, 1'b0);      // R10 single bad word
    record(3, 99, 1'b0);     // R6 exception cleared by new arm
    for (int k = 0; k < 12; k++) begin
      int n = 1 + int'($urandom % 40);
      int bad = ($urandom % 2 == 0) ? int'($urandom % n) : 99;
      record(n, bad, 1'b0);  // R6/R8 random
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule